// File: doc/BRIEF.md
# Free-Running Counter with Self-Advancing Compare Channel

This block keeps a 64-bit up-counter that software programs and reads through a 32-bit register bus, one half-word at a time. A count-enable input paces the counter. The counter steps once for every two accepted count-enable pulses, and only while the run bit is set. The reads are live: nothing is latched. Software gets a torn-free value by reading the high word, then the low word, then the high word again, and retrying if the two high reads differ.

One 64-bit compare channel watches the counter. When the channel is armed and the counter equals the compare value, a sticky match flag sets, and the interrupt output shows that flag gated by an enable bit. With auto-advance on, every match adds a 32-bit increment to the compare value, so the interrupt repeats at a fixed period without software reloading it. Every accepted write to a counter, compare or control register raises its own sticky acknowledge bit one cycle later. Software polls that bit to learn that the write has landed, and then clears it by writing a one.

Top module: `gtimer_cmp`

Register map (byte offsets): 0x00 counter low, 0x04 counter high, 0x08 counter acknowledge, 0x10 compare low, 0x14 compare high, 0x18 increment, 0x1C control, 0x20 interrupt enable, 0x24 match flag, 0x28 general acknowledge.

## Requirements
- R1: The counter is 64 bits wide. A write to 0x00 replaces bits 31:0 and a write to 0x04 replaces bits 63:32, taking effect at the write edge. Reads of these offsets return the live counter halves.
- R2: While control bit 0 (run) is set, the counter increments once for every second clock cycle with tick_en high, and the carry crosses the two halves. While run is clear, the counter holds and the pulse phase returns to zero.
- R3: While control bit 1 (arm) is set and the counter equals the compare value (0x10 low, 0x14 high), bit 0 of 0x24 sets on the next edge. It never sets while arm is clear.
- R4: While control bit 2 (auto-advance) is set, each match adds the increment register (0x18, zero-extended) to the full 64-bit compare value on the match edge, with carry into the high word.
- R5: irq is high exactly when bit 0 of 0x24 and bit 0 of 0x20 are both set.
- R6: Writing 0x24 with bit 0 set clears the match flag. A match in the same cycle wins. Writing 0x24 with bit 0 clear has no effect.
- R7: A write to 0x00 sets bit 0 of 0x08 and a write to 0x04 sets bit 1 of 0x08. The bit becomes visible after the second clock edge that follows the write.
- R8: Writes to 0x10, 0x14 and 0x18 set bits 0, 1 and 2 of 0x28, and a write to 0x1C sets bit 16 of 0x28, with the same one-cycle delay as R7.
- R9: Acknowledge bits stay set until a write of one to their own position in 0x08 or 0x28. Bits written with zero are left unchanged.
- R10: A write to any offset outside the map changes no register and sets no acknowledge bit. A read of such an offset returns zero.
- R11: After reset the counter, compare value, increment, control, enable, match flag and all acknowledge bits read zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count-enable pulse, one per reference period |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Compare interrupt |

## Verification
Timing differs by result. Register and counter writes show on the read port right after the write edge. A counter step needs the second tick cycle. The match flag, and with it irq, rises one edge after the counter reaches the compare value, and the acknowledge bits rise two edges after the write. Every bench task therefore ends at a falling edge and allows for these delays before it samples. Tick bursts are followed by one idle cycle, so that a match can register before the flag and irq are read. Each acknowledge bit is sampled once in the pending cycle, where it must still read zero, and again one cycle later, where it must read one.

// File: rtl/gtimer_pkg.sv
// Shared constants and types for the compare timer.
// Assumes a 32-bit register bus with byte offsets on an 8-bit address.
package gtimer_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 8'h00;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 8'h04;
    localparam logic [ADDR_W-1:0] A_CNT_ACK = 8'h08;
    localparam logic [ADDR_W-1:0] A_CMP_LO  = 8'h10;
    localparam logic [ADDR_W-1:0] A_CMP_HI  = 8'h14;
    localparam logic [ADDR_W-1:0] A_CMP_INC = 8'h18;
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 8'h20;
    localparam logic [ADDR_W-1:0] A_IRQ_ST  = 8'h24;
    localparam logic [ADDR_W-1:0] A_GEN_ACK = 8'h28;

    // acknowledge bit positions of the general acknowledge register
    localparam int GACK_CTRL_POS = 16;
    localparam int CNT_ACK_N     = 2;
    localparam int GEN_ACK_N     = 4;

    typedef struct packed {
        logic auto_adv;   // bit 2
        logic arm;        // bit 1
        logic run;        // bit 0
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cnt_ack;
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_inc;
        logic ctrl;
        logic irq_en;
        logic irq_st;
        logic gen_ack;
    } wstb_t;
endpackage

// File: rtl/gtimer_ack.sv
// Sticky write-acknowledge bank.
// Each hit is held one cycle in a pending flop, then set in the sticky bit.
// A clear (write of one) is ignored for a bit that is being set in that cycle.
module gtimer_ack #(
    parameter int NBITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] hit,
    input  logic             clr_we,
    input  logic [NBITS-1:0] clr_mask,
    output logic [NBITS-1:0] pend,
    output logic [NBITS-1:0] sticky
);
    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        // delay each hit by one cycle
        always_ff @(posedge clk) begin
            if (!rst_n) pend[b] <= 1'b0;
            else        pend[b] <= hit[b];
        end

        // hold the acknowledge until written with one
        always_ff @(posedge clk) begin
            if (!rst_n)                      sticky[b] <= 1'b0;
            else if (pend[b])                sticky[b] <= 1'b1;
            else if (clr_we && clr_mask[b])  sticky[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/gtimer_counter.sv
// 64-bit free-running counter with a tick prescaler.
// Assumes tick_en is synchronous to clk. A write to either half takes
// precedence over a step in the same cycle, and that step is dropped.
module gtimer_counter #(
    parameter int HALF_W   = 32,
    parameter int TICK_DIV = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                tick_en,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count
);
    localparam int PH_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICK_DIV - 1);

    logic [PH_W-1:0] phase;
    logic            step;

    assign step = run && tick_en && (phase == PH_LAST);

    // count accepted pulses modulo TICK_DIV; restart whenever stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   phase <= '0;
        else if (tick_en)     phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    // half-word loads or a single step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) count[HALF_W-1:0]        <= wdata;
            if (wr_hi) count[2*HALF_W-1:HALF_W] <= wdata;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/gtimer_compare.sv
// 64-bit compare channel with optional auto-advance.
// A match is equality while armed. On a match the flag sets and, with
// auto-advance on, the increment is added to the compare value.
// Bus writes to the compare halves win over an advance in the same cycle.
module gtimer_compare #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic                auto_adv,
    input  logic [2*HALF_W-1:0] count,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic                wr_inc,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                flag_clr,
    output logic [2*HALF_W-1:0] cmp_val,
    output logic [HALF_W-1:0]   inc_val,
    output logic                match,
    output logic                flag
);
    assign match = arm && (count == cmp_val);

    // compare value: bus load, else advance on match
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_val <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cmp_val[HALF_W-1:0]        <= wdata;
            if (wr_hi) cmp_val[2*HALF_W-1:HALF_W] <= wdata;
        end else if (match && auto_adv) begin
            cmp_val <= cmp_val + {{HALF_W{1'b0}}, inc_val};
        end
    end

    // increment register
    always_ff @(posedge clk) begin
        if (!rst_n)      inc_val <= '0;
        else if (wr_inc) inc_val <= wdata;
    end

    // sticky match flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (match)    flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/gtimer_regs.sv
// Register decode, control and enable storage, and the read mux.
// Assumes exact byte-offset decode; any other offset is unmapped.
module gtimer_regs
    import gtimer_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic [CNT_W-1:0]    count,
    input  logic [CNT_W-1:0]    cmp_val,
    input  logic [DATA_W-1:0]   inc_val,
    input  logic                flag,
    input  logic [CNT_ACK_N-1:0] cnt_ack,
    input  logic [GEN_ACK_N-1:0] gen_ack,
    output wstb_t               wstb,
    output ctrl_t               ctrl,
    output logic                irq_en,
    output logic [DATA_W-1:0]   bus_rdata
);
    // one strobe per mapped register
    always_comb begin
        wstb         = '0;
        wstb.cnt_lo  = bus_we && (bus_addr == A_CNT_LO);
        wstb.cnt_hi  = bus_we && (bus_addr == A_CNT_HI);
        wstb.cnt_ack = bus_we && (bus_addr == A_CNT_ACK);
        wstb.cmp_lo  = bus_we && (bus_addr == A_CMP_LO);
        wstb.cmp_hi  = bus_we && (bus_addr == A_CMP_HI);
        wstb.cmp_inc = bus_we && (bus_addr == A_CMP_INC);
        wstb.ctrl    = bus_we && (bus_addr == A_CTRL);
        wstb.irq_en  = bus_we && (bus_addr == A_IRQ_EN);
        wstb.irq_st  = bus_we && (bus_addr == A_IRQ_ST);
        wstb.gen_ack = bus_we && (bus_addr == A_GEN_ACK);
    end

    // control bits
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl <= '0;
        else if (wstb.ctrl) ctrl <= ctrl_t'(bus_wdata[2:0]);
    end

    // interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)           irq_en <= 1'b0;
        else if (wstb.irq_en) irq_en <= bus_wdata[0];
    end

    // live read mux, zero for unmapped offsets
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CNT_LO:  bus_rdata = count[DATA_W-1:0];
            A_CNT_HI:  bus_rdata = count[CNT_W-1:DATA_W];
            A_CNT_ACK: bus_rdata[CNT_ACK_N-1:0] = cnt_ack;
            A_CMP_LO:  bus_rdata = cmp_val[DATA_W-1:0];
            A_CMP_HI:  bus_rdata = cmp_val[CNT_W-1:DATA_W];
            A_CMP_INC: bus_rdata = inc_val;
            A_CTRL:    bus_rdata[2:0] = ctrl;
            A_IRQ_EN:  bus_rdata[0] = irq_en;
            A_IRQ_ST:  bus_rdata[0] = flag;
            A_GEN_ACK: begin
                bus_rdata[2:0]           = gen_ack[2:0];
                bus_rdata[GACK_CTRL_POS] = gen_ack[3];
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gtimer_cmp.sv
// Top of the compare timer: counter, compare channel, two acknowledge
// banks and the register block. irq is the match flag gated by its enable.
// Assumes every port is synchronous to clk.
module gtimer_cmp
    import gtimer_pkg::*;
#(
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    wstb_t                 wstb;
    ctrl_t                 ctrl_q;
    logic                  irq_en;
    logic [CNT_W-1:0]      count;
    logic [CNT_W-1:0]      cmp_val;
    logic [DATA_W-1:0]     inc_val;
    logic                  match;
    logic                  flag;
    logic [CNT_ACK_N-1:0]  cnt_pend, cnt_ack;
    logic [GEN_ACK_N-1:0]  gen_pend, gen_ack;

    gtimer_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .count(count), .cmp_val(cmp_val), .inc_val(inc_val),
        .flag(flag), .cnt_ack(cnt_ack), .gen_ack(gen_ack), .wstb(wstb),
        .ctrl(ctrl_q), .irq_en(irq_en), .bus_rdata(bus_rdata)
    );

    gtimer_counter #(.HALF_W(DATA_W), .TICK_DIV(TICK_DIV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .tick_en(tick_en),
        .wr_lo(wstb.cnt_lo), .wr_hi(wstb.cnt_hi), .wdata(bus_wdata),
        .count(count)
    );

    gtimer_compare #(.HALF_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .arm(ctrl_q.arm), .auto_adv(ctrl_q.auto_adv),
        .count(count), .wr_lo(wstb.cmp_lo), .wr_hi(wstb.cmp_hi),
        .wr_inc(wstb.cmp_inc), .wdata(bus_wdata),
        .flag_clr(wstb.irq_st && bus_wdata[0]),
        .cmp_val(cmp_val), .inc_val(inc_val), .match(match), .flag(flag)
    );

    gtimer_ack #(.NBITS(CNT_ACK_N)) u_cnt_ack (
        .clk(clk), .rst_n(rst_n),
        .hit({wstb.cnt_hi, wstb.cnt_lo}),
        .clr_we(wstb.cnt_ack), .clr_mask(bus_wdata[CNT_ACK_N-1:0]),
        .pend(cnt_pend), .sticky(cnt_ack)
    );

    gtimer_ack #(.NBITS(GEN_ACK_N)) u_gen_ack (
        .clk(clk), .rst_n(rst_n),
        .hit({wstb.ctrl, wstb.cmp_inc, wstb.cmp_hi, wstb.cmp_lo}),
        .clr_we(wstb.gen_ack),
        .clr_mask({bus_wdata[GACK_CTRL_POS], bus_wdata[2:0]}),
        .pend(gen_pend), .sticky(gen_ack)
    );

    assign irq = flag && irq_en;
endmodule

// File: rtl/gtimer_cmp_chk.sv
// Property checker for gtimer_cmp, attached by bind below.
module gtimer_cmp_chk
    import gtimer_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic                 bus_we,
    input logic                 run,
    input logic                 arm,
    input logic                 auto_adv,
    input logic [CNT_W-1:0]     count,
    input logic [CNT_W-1:0]     cmp_val,
    input logic [DATA_W-1:0]    inc_val,
    input logic                 match,
    input logic                 flag,
    input logic [CNT_ACK_N-1:0] cnt_pend,
    input logic [CNT_ACK_N-1:0] cnt_ack,
    input logic [GEN_ACK_N-1:0] gen_pend,
    input logic [GEN_ACK_N-1:0] gen_ack
);
    logic unmapped;
    assign unmapped = !(bus_addr inside {A_CNT_LO, A_CNT_HI, A_CNT_ACK, A_CMP_LO,
                        A_CMP_HI, A_CMP_INC, A_CTRL, A_IRQ_EN, A_IRQ_ST, A_GEN_ACK});

    assert_cnt_hi_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CNT_HI) |=> count[CNT_W-1:DATA_W] == $past(bus_wdata));

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_we) |=> $stable(count));

    assert_flag_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(arm));

    assert_auto_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_adv && !bus_we) |=> cmp_val == $past(cmp_val) + {{DATA_W{1'b0}}, $past(inc_val)});

    assert_clear_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_IRQ_ST && bus_wdata[0] && !match) |=> !flag);

    assert_cnt_ack_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CNT_LO) |=> ##1 cnt_ack[0]);

    assert_ctrl_ack_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CTRL) |=> ##1 gen_ack[3]);

    assert_unmapped_no_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && unmapped) |=> (cnt_pend == '0 && gen_pend == '0));
endmodule

bind gtimer_cmp gtimer_cmp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .run(ctrl_q.run), .arm(ctrl_q.arm),
    .auto_adv(ctrl_q.auto_adv), .count(count), .cmp_val(cmp_val),
    .inc_val(inc_val), .match(match), .flag(flag), .cnt_pend(cnt_pend),
    .cnt_ack(cnt_ack), .gen_pend(gen_pend), .gen_ack(gen_ack)
);

// File: tb/sim_gtimer_cmp.sv
module sim_gtimer_cmp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_cnt = '0;
    bit          m_run = 0;
    bit          m_ph = 0;

    gtimer_cmp u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic logic [63:0] next_cnt(logic [63:0] c, bit ph);
        return ph ? c + 64'd1 : c;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        if (a == 8'h00) m_cnt[31:0] = d;
        if (a == 8'h04) m_cnt[63:32] = d;
        if (a == 8'h1C) begin
            m_run = d[0];
            if (!d[0]) m_ph = 0;
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            if (m_run) begin
                m_cnt = next_cnt(m_cnt, m_ph);
                m_ph = !m_ph;
            end
        end
        @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_cnt(string tag);
        logic [31:0] lo, hi;
        rd(8'h00, lo);
        rd(8'h04, hi);
        chk(tag, {hi, lo}, m_cnt);
    endtask

    task automatic chk_reg(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, {32'd0, v}, {32'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk_reg("R11 cnt lo", 8'h00, 0);
        chk_reg("R11 cnt hi", 8'h04, 0);
        chk_reg("R11 ctrl", 8'h1C, 0);
        chk_reg("R11 cmp lo", 8'h10, 0);
        chk_reg("R11 flag", 8'h24, 0);
        chk_reg("R11 cnt ack", 8'h08, 0);
        chk_reg("R11 gen ack", 8'h28, 0);
        chk("R11 irq", {63'd0, irq}, 0);

        // R7 / R1 counter writes and acknowledge delay
        wr(8'h00, 32'hFFFF_FFFE);
        chk_reg("R7 ack pending", 8'h08, 0);
        idle(1);
        chk_reg("R7 ack lo set", 8'h08, 1);
        wr(8'h04, 32'h12);
        idle(1);
        chk_reg("R7 ack both", 8'h08, 3);
        chk_cnt("R1 counter load");
        // R9 write-one clear, other bit stays
        wr(8'h08, 1);
        chk_reg("R9 clear bit0", 8'h08, 2);
        wr(8'h08, 0);
        chk_reg("R9 zero write keeps", 8'h08, 2);
        wr(8'h08, 2);
        chk_reg("R9 clear bit1", 8'h08, 0);

        // R2 counting with carry across halves
        wr(8'h1C, 1);
        ticks(5);
        chk_cnt("R2 carry across halves");
        chk_reg("R8 ctrl ack bit16", 8'h28, 32'h0001_0000);
        ticks(1);
        chk_cnt("R2 odd phase step");
        wr(8'h1C, 0);
        ticks(4);
        chk_cnt("R2 hold while stopped");
        wr(8'h1C, 1);
        ticks(1);
        chk_cnt("R2 phase restart");
        ticks(1);
        chk_cnt("R2 step after restart");
        wr(8'h28, 32'h0001_0000);
        chk_reg("R9 gen ack clear", 8'h28, 0);

        // R3 / R5 one-shot match
        wr(8'h1C, 0);
        wr(8'h00, 0);
        wr(8'h04, 0);
        wr(8'h10, 10);
        wr(8'h14, 0);
        wr(8'h20, 1);
        wr(8'h1C, 3);
        idle(1);
        chk_reg("R8 cmp lo/hi + ctrl ack", 8'h28, 32'h0001_0003);
        ticks(19);
        chk_cnt("R2 count to 9");
        chk("R3 no early match", {63'd0, irq}, 0);
        ticks(1);
        chk_cnt("R2 count to 10");
        chk("R5 irq on match", {63'd0, irq}, 1);
        ticks(4);
        chk_reg("R3 flag sticky", 8'h24, 1);
        wr(8'h24, 0);
        chk_reg("R6 write zero keeps", 8'h24, 1);
        wr(8'h24, 1);
        chk("R6 cleared irq", {63'd0, irq}, 0);

        // R3 disarmed, R5 masking, R6 match wins
        wr(8'h20, 0);
        wr(8'h1C, 0);
        wr(8'h00, 10);
        idle(2);
        chk_reg("R3 disarmed no flag", 8'h24, 0);
        wr(8'h1C, 2);
        idle(1);
        chk_reg("R3 armed flag", 8'h24, 1);
        chk("R5 masked irq", {63'd0, irq}, 0);
        wr(8'h20, 1);
        chk("R5 unmasked irq", {63'd0, irq}, 1);
        wr(8'h24, 1);
        chk_reg("R6 match beats clear", 8'h24, 1);
        wr(8'h1C, 0);
        wr(8'h24, 1);
        chk_reg("R6 clear after disarm", 8'h24, 0);

        // R4 periodic advance
        wr(8'h28, 32'h0001_0007);
        wr(8'h00, 0);
        wr(8'h10, 10);
        wr(8'h18, 6);
        wr(8'h1C, 7);
        idle(1);
        chk_reg("R8 inc ack bit2", 8'h28, 32'h0001_0005);
        ticks(20);
        chk("R4 first period irq", {63'd0, irq}, 1);
        chk_reg("R4 compare advanced", 8'h10, 16);
        wr(8'h24, 1);
        chk("R6 clear between periods", {63'd0, irq}, 0);
        ticks(12);
        chk("R4 second period irq", {63'd0, irq}, 1);
        chk_reg("R4 compare advanced again", 8'h10, 22);

        // R4 carry into high word
        wr(8'h1C, 0);
        wr(8'h24, 1);
        wr(8'h00, 32'hFFFF_FFF0);
        wr(8'h04, 5);
        wr(8'h10, 32'hFFFF_FFF0);
        wr(8'h14, 5);
        wr(8'h18, 32'h20);
        wr(8'h1C, 6);
        idle(1);
        chk_reg("R4 carry high", 8'h14, 6);
        chk_reg("R4 carry low", 8'h10, 32'h10);
        chk_reg("R4 inc readback", 8'h18, 32'h20);

        // R10 unmapped writes
        wr(8'h1C, 0);
        wr(8'h08, 3);
        wr(8'h28, 32'h0001_0007);
        idle(2);
        wr(8'h3C, 32'hFFFF_FFFF);
        wr(8'h02, 32'hFFFF_FFFF);
        idle(2);
        chk_reg("R10 no cnt ack", 8'h08, 0);
        chk_reg("R10 no gen ack", 8'h28, 0);
        chk_reg("R10 read zero", 8'h3C, 0);
        chk_cnt("R10 counter untouched");
        chk_reg("R10 ctrl untouched", 8'h1C, 0);

        // R1 / R2 / R7 random counter loads and bursts
        for (int it = 0; it < 40; it++) begin
            logic [31:0] lo, hi;
            int n;
            lo = $urandom;
            hi = $urandom;
            if (lo[0]) lo = 32'hFFFF_FFFF - ($urandom % 8);
            n = $urandom % 40;
            wr(8'h1C, 0);
            wr(8'h00, lo);
            wr(8'h04, hi);
            wr(8'h1C, 1);
            ticks(n);
            chk_cnt("R2 random burst");
            chk_reg("R7 random ack", 8'h08, 3);
            wr(8'h08, 3);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule